// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wake-Up

This block receives asynchronous serial frames of 10 or 11 bits: one start bit, 8 or 9 data bits sent least significant bit first, and one stop bit. A 16x oversampling tick paces it, and that tick comes from outside the block. Each bit is sampled three times around its centre and decided by a majority of the three samples. The data byte, the ninth bit and five status flags (data-full, idle-line, overrun, noise, framing error) are presented on plain output ports. A single acknowledge strobe clears all the flags.

For multi-drop links, software can send the receiver to sleep. While it sleeps the receiver sets no status flag, and any flag that was already set keeps its value. The wake-method input picks how it wakes:

- **Idle-line method:** it wakes after a run of consecutive ones as long as a full frame.
- **Address-mark method:** it wakes on a frame whose most significant data bit is set. That frame is then delivered as ordinary received data.

Top module: `sio_rx_wake`

## Requirements
- R1: After a synchronous reset, rx_data and rx_bit8 are 0, all five flags are 0, and rx_asleep is 0.
- R2: With nine_bit=0, a frame with 8 data bits (LSB first) and a high stop bit loads rx_data, sets rx_bit8 to 0 and sets rx_full.
- R3: With nine_bit=1, the frame carries 9 data bits. The ninth data bit appears on rx_bit8.
- R4: Each bit is decided by a 2-of-3 vote over the samples at oversampling ticks 7, 8 and 9 of that bit, counted from the tick that first sees the start bit low. If the three samples of any bit in the frame disagree, rx_noise is set with that frame.
- R5: A stop bit decided as low sets rx_ferr. The frame's data is still stored and rx_full is still set.
- R6: A frame that completes while rx_full is 1 sets rx_ovr and leaves rx_data and rx_bit8 unchanged.
- R7: rx_idle is set once when the line has stayed high for 10 bit times (nine_bit=0) or 11 bit times (nine_bit=1), provided a frame has been received since the last time rx_idle was set. A continued idle line does not set it again.
- R8: While rx_en is 0, all five flags are held at 0 and incoming frames set none of them.
- R9: While rx_asleep is 1, no flag is set and rx_data is not written. Flags that were already set stay set.
- R10: With wake_mark=0, rx_asleep clears after the line has stayed high for 10 or 11 bit times (chosen by nine_bit), and not before.
- R11: With wake_mark=0, a sleep_set pulse has no effect while the line is already idle (10 or 11 bit times of ones).
- R12: With wake_mark=1, sleep_set is accepted at any time. A frame whose top data bit is 0 (bit 7 when nine_bit=0, bit 8 when nine_bit=1) leaves the receiver asleep and is discarded. A frame whose top data bit is 1 clears rx_asleep, is stored and sets rx_full.
- R13: A status_ack pulse clears all five flags.
- R14: A start bit whose vote comes out high is treated as a false start. It produces no frame and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 0: 8 data bits, 1: 9 data bits |
| wake_mark | input | 1 | Wake method: 0 idle-line, 1 address mark |
| sleep_set | input | 1 | Request to enter sleep (one-cycle pulse) |
| status_ack | input | 1 | Clears all status flags (one-cycle pulse) |
| rx_data | output | 8 | Received data bits 7..0 |
| rx_bit8 | output | 1 | Ninth received data bit |
| rx_full | output | 1 | Data-full flag |
| rx_idle | output | 1 | Idle-line flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_noise | output | 1 | Noise flag |
| rx_ferr | output | 1 | Framing-error flag |
| rx_asleep | output | 1 | Sleep state, cleared by the wake-up logic |

## Verification
A table of frames exercises reception. It covers alternating, all-zero and all-one bytes in both frame lengths, so a wrong bit order or a dropped ninth bit shows up as a changed data value. Single-sample glitches placed on a data bit and on the start bit separate the majority decision from the noise flag. A low stop bit separates framing from data loss. The idle-line gaps are measured just below and just above the frame-length threshold, which pins down the count that drives both the idle flag and the idle-line wake. Address frames with the top bit clear and then set show whether a wake-up frame is discarded or delivered.

// File: rtl/sio_rx_pkg.sv
`timescale 1ns/1ps
package sio_rx_pkg;

    localparam int DATA_MAX  = 9;   // widest data field
    localparam int FRAME_MAX = 11;  // start + 9 data + stop

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_STOP
    } fr_state_e;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                stop_ok;
        logic                noisy;
    } rx_frame_t;

    typedef struct packed {
        logic full;
        logic idle;
        logic ovr;
        logic noise;
        logic ferr;
    } rx_flags_t;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic split3(input logic a, input logic b, input logic c);
        return (a ^ b) | (b ^ c);
    endfunction

    function automatic int unsigned frame_bits(input logic nine);
        return nine ? 32'd11 : 32'd10;
    endfunction

    function automatic logic addr_mark(input logic [DATA_MAX-1:0] d, input logic nine);
        return nine ? d[8] : d[7];
    endfunction

endpackage

// File: rtl/sio_rx_line.sv
`timescale 1ns/1ps
module sio_rx_line
    import sio_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic os_tick,
    input  logic rxd,
    input  logic nine_bit,
    output logic line,
    output logic line_idle
);
    localparam int MAXRUN = OSR * FRAME_MAX;
    localparam int RUN_W  = $clog2(MAXRUN + 1);

    logic             meta;
    logic [RUN_W-1:0] run_cnt;
    logic [RUN_W-1:0] run_need;

    // Two-flop synchronizer, then a tick counter of consecutive ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta    <= 1'b1;
            line    <= 1'b1;
            run_cnt <= '0;
        end else begin
            meta <= rxd;
            line <= meta;
            if (!line)
                run_cnt <= '0;
            else if (os_tick && run_cnt != RUN_W'(MAXRUN))
                run_cnt <= run_cnt + 1'b1;
        end
    end

    assign run_need  = RUN_W'(OSR * frame_bits(nine_bit));
    assign line_idle = (run_cnt >= run_need);

    AST_RUN_BREAK: assert property (@(posedge clk) disable iff (rst)
        (!line) |=> !line_idle); // R10

endmodule

// File: rtl/sio_rx_framer.sv
`timescale 1ns/1ps
module sio_rx_framer
    import sio_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_en,
    input  logic      os_tick,
    input  logic      line,
    input  logic      nine_bit,
    output logic      done,
    output rx_frame_t frame
);
    localparam int PH_W  = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_MAX);
    localparam logic [PH_W-1:0] PH_A   = PH_W'(OSR/2 - 1);
    localparam logic [PH_W-1:0] PH_B   = PH_W'(OSR/2);
    localparam logic [PH_W-1:0] PH_C   = PH_W'(OSR/2 + 1);
    localparam logic [PH_W-1:0] PH_END = PH_W'(OSR - 1);

    fr_state_e           state;
    logic [PH_W-1:0]     ph;
    logic [IDX_W-1:0]    idx;
    logic [IDX_W-1:0]    last_idx;
    logic                s_a, s_b, noisy;
    logic [DATA_MAX-1:0] shreg;
    logic                bit_v, bit_n;

    assign bit_v    = vote3(s_a, s_b, line);
    assign bit_n    = split3(s_a, s_b, line);
    assign last_idx = nine_bit ? IDX_W'(8) : IDX_W'(7);

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            state <= FR_IDLE;
            ph    <= '0;
            idx   <= '0;
            s_a   <= 1'b1;
            s_b   <= 1'b1;
            noisy <= 1'b0;
            shreg <= '0;
            done  <= 1'b0;
            if (rst)
                frame <= '0;
        end else begin
            done <= 1'b0;
            if (os_tick) begin
                if (state == FR_IDLE) begin
                    if (!line) begin
                        state <= FR_START;
                        ph    <= PH_W'(1);
                        idx   <= '0;
                        noisy <= 1'b0;
                        shreg <= '0;
                    end
                end else begin
                    ph <= (ph == PH_END) ? '0 : ph + 1'b1;
                    if (ph == PH_A) s_a <= line;
                    if (ph == PH_B) s_b <= line;
                    if (ph == PH_C) begin
                        case (state)
                            FR_START: begin
                                if (bit_v) state <= FR_IDLE;   // false start
                                else       noisy <= bit_n;
                            end
                            FR_DATA: begin
                                shreg[idx] <= bit_v;
                                noisy      <= noisy | bit_n;
                            end
                            FR_STOP: begin
                                done          <= 1'b1;
                                frame.data    <= shreg;
                                frame.stop_ok <= bit_v;
                                frame.noisy   <= noisy | bit_n;
                                state         <= FR_IDLE;
                            end
                            default: ;
                        endcase
                    end
                    if (ph == PH_END) begin
                        if (state == FR_START)
                            state <= FR_DATA;
                        else if (state == FR_DATA) begin
                            if (idx == last_idx) state <= FR_STOP;
                            else                 idx   <= idx + 1'b1;
                        end
                    end
                end
            end
        end
    end

    AST_PH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !os_tick) |=> $stable(ph)); // R4

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2

endmodule

// File: rtl/sio_rx_status.sv
`timescale 1ns/1ps
module sio_rx_status
    import sio_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_en,
    input  logic                nine_bit,
    input  logic                wake_mark,
    input  logic                sleep_set,
    input  logic                status_ack,
    input  logic                line_idle,
    input  logic                done,
    input  rx_frame_t           frame,
    output logic [DATA_MAX-1:0] data_q,
    output rx_flags_t           flags,
    output logic                asleep
);
    logic       idle_seen, armed;
    logic       addr_hit, take, idle_edge;
    logic [4:0] fl_v;

    assign addr_hit  = addr_mark(frame.data, nine_bit);
    assign take      = done && (!asleep || (wake_mark && addr_hit));
    assign idle_edge = line_idle && !idle_seen;
    assign fl_v      = flags;

    // Sleep state: set by request, cleared only by the wake-up logic.
    always_ff @(posedge clk) begin
        if (rst) begin
            asleep <= 1'b0;
        end else if (asleep) begin
            if ((!wake_mark && line_idle) || (wake_mark && done && addr_hit))
                asleep <= 1'b0;
        end else if (sleep_set && (wake_mark || !line_idle)) begin
            asleep <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_seen <= 1'b0;
            armed     <= 1'b0;
            flags     <= '0;
            data_q    <= '0;
        end else begin
            idle_seen <= line_idle;
            if (!rx_en) begin
                flags <= '0;
                armed <= 1'b0;
            end else begin
                if (status_ack)
                    flags <= '0;
                if (idle_edge && armed && !asleep) begin
                    flags.idle <= 1'b1;
                    armed      <= 1'b0;
                end
                if (take) begin
                    armed <= 1'b1;
                    if (flags.full) begin
                        flags.ovr <= 1'b1;
                    end else begin
                        data_q      <= frame.data;
                        flags.full  <= 1'b1;
                        flags.ferr  <= !frame.stop_ok;
                        flags.noise <= frame.noisy;
                    end
                end
            end
        end
    end

    AST_EN_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        (!rx_en) |=> (fl_v == 5'b0)); // R8

    AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (asleep && !done) |=> ((fl_v & ~$past(fl_v)) == 5'b0)); // R9

    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rx_en && flags.full && done) |=> $stable(data_q)); // R6

    AST_ADDR_NOWAKE: assert property (@(posedge clk) disable iff (rst)
        (asleep && wake_mark && done && !addr_hit) |=> asleep); // R12

    AST_IDLE_REQ: assert property (@(posedge clk) disable iff (rst)
        (!asleep && !wake_mark && line_idle && sleep_set) |=> !asleep); // R11

endmodule

// File: rtl/sio_rx_wake.sv
`timescale 1ns/1ps
module sio_rx_wake
    import sio_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       rx_en,
    input  logic       nine_bit,
    input  logic       wake_mark,
    input  logic       sleep_set,
    input  logic       status_ack,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       rx_full,
    output logic       rx_idle,
    output logic       rx_ovr,
    output logic       rx_noise,
    output logic       rx_ferr,
    output logic       rx_asleep
);
    logic                line, line_idle, done;
    rx_frame_t           frame;
    rx_flags_t           flags;
    logic [DATA_MAX-1:0] data_q;

    sio_rx_line #(.OSR(OSR)) u_line (
        .clk       (clk),
        .rst       (rst),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .nine_bit  (nine_bit),
        .line      (line),
        .line_idle (line_idle)
    );

    sio_rx_framer #(.OSR(OSR)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (rx_en),
        .os_tick  (os_tick),
        .line     (line),
        .nine_bit (nine_bit),
        .done     (done),
        .frame    (frame)
    );

    sio_rx_status u_status (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .nine_bit   (nine_bit),
        .wake_mark  (wake_mark),
        .sleep_set  (sleep_set),
        .status_ack (status_ack),
        .line_idle  (line_idle),
        .done       (done),
        .frame      (frame),
        .data_q     (data_q),
        .flags      (flags),
        .asleep     (rx_asleep)
    );

    assign rx_data  = data_q[7:0];
    assign rx_bit8  = data_q[8];
    assign rx_full  = flags.full;
    assign rx_idle  = flags.idle;
    assign rx_ovr   = flags.ovr;
    assign rx_noise = flags.noise;
    assign rx_ferr  = flags.ferr;

endmodule

// File: tb/sio_rx_wake_test.sv
`timescale 1ns/1ps
module sio_rx_wake_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] tcnt = 2'd0;
    logic       os_tick;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic       nine_bit = 1'b0;
    logic       wake_mark = 1'b0;
    logic       sleep_set = 1'b0;
    logic       status_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8, rx_full, rx_idle, rx_ovr, rx_noise, rx_ferr, rx_asleep;

    int checks = 0;
    int fails  = 0;
    bit done_all = 1'b0;

    always #2.5 clk = ~clk;
    always_ff @(posedge clk) tcnt <= tcnt + 2'd1;
    assign os_tick = (tcnt == 2'd3);

    sio_rx_wake uut (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
        .nine_bit(nine_bit), .wake_mark(wake_mark), .sleep_set(sleep_set),
        .status_ack(status_ack), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .rx_full(rx_full), .rx_idle(rx_idle), .rx_ovr(rx_ovr),
        .rx_noise(rx_noise), .rx_ferr(rx_ferr), .rx_asleep(rx_asleep)
    );

    typedef struct packed {
        logic       nine;
        logic [8:0] d;
        logic [3:0] gl;     // bit index to glitch: 0 start, 1..n data, 15 none
        logic       stopv;
        logic       exp_n;
        logic       exp_f;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 9'h055, 4'd15, 1'b1, 1'b0, 1'b0},
        '{1'b0, 9'h0A3, 4'd15, 1'b1, 1'b0, 1'b0},
        '{1'b0, 9'h000, 4'd15, 1'b1, 1'b0, 1'b0},
        '{1'b0, 9'h0FF, 4'd15, 1'b1, 1'b0, 1'b0},
        '{1'b1, 9'h1A5, 4'd15, 1'b1, 1'b0, 1'b0},
        '{1'b1, 9'h0F0, 4'd15, 1'b1, 1'b0, 1'b0},
        '{1'b0, 9'h03C, 4'd3,  1'b1, 1'b1, 1'b0},
        '{1'b1, 9'h100, 4'd0,  1'b1, 1'b1, 1'b0},
        '{1'b0, 9'h081, 4'd15, 1'b0, 1'b0, 1'b1},
        '{1'b0, 9'h06E, 4'd15, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick_wait();
        do @(negedge clk); while (!os_tick);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_wait();
    endtask

    task automatic drive_bit(input logic v, input bit glitch, input bit sl);
        for (int t = 0; t < 16; t++) begin
            rxd = (glitch && t == 8) ? ~v : v;
            if (sl && t == 3) begin
                sleep_set = 1'b1;
                @(negedge clk);
                sleep_set = 1'b0;
            end
            tick_wait();
        end
    endtask

    task automatic send_frame(input logic nine, input logic [8:0] d, input logic [3:0] gl,
                              input logic stopv, input bit sl);
        int n;
        n = nine ? 9 : 8;
        drive_bit(1'b0, gl == 4'd0, sl);
        for (int i = 0; i < n; i++) drive_bit(d[i], gl == 4'(i + 1), 1'b0);
        drive_bit(stopv, gl == 4'(n + 1), 1'b0);
        rxd = 1'b1;
    endtask

    task automatic pulse_ack();
        status_ack = 1'b1;
        @(negedge clk);
        status_ack = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep_set = 1'b1;
        @(negedge clk);
        sleep_set = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [4:0] flags_now();
        return {rx_full, rx_idle, rx_ovr, rx_noise, rx_ferr};
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "data", {7'd0, rx_bit8, rx_data}, 16'h0);
        chk("R1", "flags", 16'(flags_now()), 16'h0);
        chk("R1", "asleep", 16'(rx_asleep), 16'h0);
        tick_wait();

        // R2 R3 R4 R5: table of frames
        for (int k = 0; k < NVEC; k++) begin
            string tag;
            logic [8:0] expd;
            tag  = VEC[k].exp_f ? "R5" : (VEC[k].exp_n ? "R4" : (VEC[k].nine ? "R3" : "R2"));
            expd = VEC[k].nine ? VEC[k].d : {1'b0, VEC[k].d[7:0]};
            nine_bit = VEC[k].nine;
            pulse_ack();
            send_frame(VEC[k].nine, VEC[k].d, VEC[k].gl, VEC[k].stopv, 1'b0);
            chk(tag, "data", {7'd0, rx_bit8, rx_data}, {7'd0, expd});
            chk(tag, "full", 16'(rx_full), 16'h1);
            chk(tag, "noise", 16'(rx_noise), 16'(VEC[k].exp_n));
            chk(tag, "ferr", 16'(rx_ferr), 16'(VEC[k].exp_f));
            ticks(12);
        end

        // R6: overrun keeps old data
        nine_bit = 1'b0;
        send_frame(1'b0, 9'h05A, 4'd15, 1'b1, 1'b0);
        chk("R6", "ovr", 16'(rx_ovr), 16'h1);
        chk("R6", "data kept", {7'd0, rx_bit8, rx_data}, 16'h06E);

        // R13: acknowledge clears all flags
        pulse_ack();
        chk("R13", "flags", 16'(flags_now()), 16'h0);

        // R14: false start
        for (int t = 0; t < 4; t++) begin rxd = 1'b0; tick_wait(); end
        rxd = 1'b1;
        ticks(20);
        chk("R14", "flags", 16'(flags_now()), 16'h0);

        // R7: idle flag after a full frame time of ones, only once
        ticks(200);
        pulse_ack();
        send_frame(1'b0, 9'h012, 4'd15, 1'b1, 1'b0);
        ticks(128);
        chk("R7", "idle early", 16'(rx_idle), 16'h0);
        ticks(32);
        chk("R7", "idle set", 16'(rx_idle), 16'h1);
        pulse_ack();
        ticks(200);
        chk("R7", "idle once", 16'(rx_idle), 16'h0);

        // R9 R10: sleep with idle-line wake
        pulse_ack();
        send_frame(1'b0, 9'h02C, 4'd15, 1'b1, 1'b0);
        ticks(4);
        send_frame(1'b0, 9'h033, 4'd15, 1'b1, 1'b1);
        chk("R9", "asleep", 16'(rx_asleep), 16'h1);
        chk("R9", "data frozen", {7'd0, rx_bit8, rx_data}, 16'h02C);
        ticks(4);
        send_frame(1'b0, 9'h044, 4'd15, 1'b1, 1'b0);
        chk("R9", "flags kept", 16'(flags_now()), 16'h10);
        chk("R9", "data frozen 2", {7'd0, rx_bit8, rx_data}, 16'h02C);
        ticks(128);
        chk("R10", "still asleep", 16'(rx_asleep), 16'h1);
        ticks(32);
        chk("R10", "woken", 16'(rx_asleep), 16'h0);
        chk("R9", "no idle on wake", 16'(rx_idle), 16'h0);

        // R11: sleep request ignored on an idle line
        pulse_sleep();
        chk("R11", "asleep", 16'(rx_asleep), 16'h0);

        // R12: address-mark wake, 8-bit then 9-bit
        wake_mark = 1'b1;
        pulse_ack();
        pulse_sleep();
        chk("R12", "asleep", 16'(rx_asleep), 16'h1);
        send_frame(1'b0, 9'h015, 4'd15, 1'b1, 1'b0);
        ticks(4);
        chk("R12", "no wake", 16'({rx_asleep, rx_full}), 16'h2);
        send_frame(1'b0, 9'h095, 4'd15, 1'b1, 1'b0);
        ticks(4);
        chk("R12", "wake", 16'({rx_asleep, rx_full}), 16'h1);
        chk("R12", "data", {7'd0, rx_bit8, rx_data}, 16'h095);
        nine_bit = 1'b1;
        pulse_ack();
        pulse_sleep();
        send_frame(1'b1, 9'h0FF, 4'd15, 1'b1, 1'b0);
        ticks(4);
        chk("R12", "9b no wake", 16'({rx_asleep, rx_full}), 16'h2);
        send_frame(1'b1, 9'h101, 4'd15, 1'b1, 1'b0);
        ticks(4);
        chk("R12", "9b wake", 16'({rx_asleep, rx_full}), 16'h1);
        chk("R12", "9b data", {7'd0, rx_bit8, rx_data}, 16'h101);

        // R8: disabled receiver inhibits flags
        wake_mark = 1'b0;
        nine_bit = 1'b0;
        rx_en = 1'b0;
        @(negedge clk);
        chk("R8", "cleared", 16'(flags_now()), 16'h0);
        send_frame(1'b0, 9'h066, 4'd15, 1'b1, 1'b0);
        chk("R8", "inhibited", 16'(flags_now()), 16'h0);
        rx_en = 1'b1;
        ticks(4);
        chk("R8", "after enable", 16'(flags_now()), 16'h0);

        done_all = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_all) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule